// File: doc/BRIEF.md
# Configurable pixel input capture

This block is the front end of a video link transmitter. A parallel pixel bus is sampled against a pixel clock, and the block rebuilds whole pixels according to a configured mode. There are three width modes. The half-width mode carries each pixel as two 12-bit pieces. The full-width mode carries one 18- or 24-bit pixel per sampling edge. The double-width mode carries two pixels side by side on one edge. Sampling can use the rising edge of the pixel clock, the falling edge, or both. In the half-width mode a second clock input can take the place of the falling edge.

Every result leaves on the rising edge of the primary clock, in two 24-bit pixel slots that each carry a valid flag. Samples taken on the falling edge, or on the second clock input, are held in their own register. The rising edge that follows moves them into the output slots. Slot 0 always carries the earlier pixel in time.

Top module: `pixcap_top`

## Requirements
- R1: While the synchronous reset is high at a rising edge of `clk_p`, that edge clears both slot valids and the error flag.
- R2: Width mode 01 (full) with edge select 01 (rising): the pixel on `pix_in[23:0]` at a rising edge appears in slot 0 at that edge. Slot 0 is valid and slot 1 is not.
- R3: With `cfg_wide` low, outside the half-width mode, each pixel is 18 bits wide. Lane 0 is `[17:0]` and lane 1 is `[35:18]`. Each is zero-extended, so bits 23:18 of a valid slot read zero. With `cfg_wide` high, lane 0 is `[23:0]` and lane 1 is `[47:24]`.
- R4: Edge select 10 (falling): the pixel sampled on a falling edge is presented at the next rising edge. The rising edge immediately after reset or a configuration change presents no falling-edge data.
- R5: Full-width mode with edge select 11 (both): slot 0 holds the pixel from the falling edge and slot 1 the pixel from the following rising edge. On the first rising edge after reset, only slot 1 is valid.
- R6: Width mode 00 (half) with `cfg_low_on_rise` high: bits 11:0 taken on a rising edge form pixel bits 11:0, and bits 11:0 taken on the next falling edge form bits 23:12. The pixel is valid in slot 0 at the rising edge after that, and only once both pieces were taken after reset.
- R7: Half-width mode with `cfg_low_on_rise` low: the falling-edge piece is bits 11:0 and the following rising-edge piece is bits 23:12. The pixel is presented at that rising edge.
- R8: Half-width mode with `cfg_two_clk` high: the piece normally taken on the falling edge of `clk_p` is taken on the rising edge of `clk_n` instead. The order bit keeps the meaning it has in R6 and R7.
- R9: Width mode 10 (double) with edge select 01 or 10: lane 0 goes to slot 0 and lane 1 to slot 1, both valid, taken on the selected edge.
- R10: Width mode 11, or double-width mode with edge select 11, is illegal. It sets `cfg_err`, which stays set until reset, and no slot is valid while the configuration is illegal.
- R11: At a rising edge where any configuration input differs from its value at the previous edge, no slot is valid. Any partly assembled half-width pixel is dropped.
- R12: Edge select 00 in full- or double-width mode captures nothing, and no slot is valid.
- R13: The half-width mode only ever presents a pixel in slot 0. Slot 1 stays invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_p | input | 1 | Primary pixel clock; all outputs change on its rising edge |
| clk_n | input | 1 | Second clock input for the two-clock half-width variant; tied low otherwise |
| rst | input | 1 | Synchronous active-high reset in the `clk_p` domain |
| cfg_wmode | input | 2 | Width mode: 00 half, 01 full, 10 double, 11 illegal |
| cfg_edge | input | 2 | Edge select: 00 none, 01 rising, 10 falling, 11 both |
| cfg_wide | input | 1 | 1 = 24-bit pixels, 0 = 18-bit pixels |
| cfg_low_on_rise | input | 1 | Half-width order: 1 = low piece on the rising edge of `clk_p` |
| cfg_two_clk | input | 1 | Half-width variant taking the second piece on the rising edge of `clk_n` |
| pix_in | input | 48 | Parallel pixel bus |
| slot0_pix | output | 24 | Earlier (or only) pixel |
| slot0_vld | output | 1 | Slot 0 holds a pixel |
| slot1_pix | output | 24 | Later pixel |
| slot1_vld | output | 1 | Slot 1 holds a pixel |
| cfg_err | output | 1 | Sticky illegal-configuration flag |

## Verification
The assertions check the following on every cycle:
- reset clears the outputs, and the error flag stays set once raised;
- valid stays low under an illegal configuration, with no edge selected, or on a configuration change;
- the narrow-pixel zero-extension holds, and the half-width mode never fills slot 1.

Some behaviours only the bench scenarios can show, by comparing each output edge with a reference model:
- which piece lands in which half of a rebuilt pixel, for both orders and for the two-clock variant;
- the earlier/later ordering of slots in both-edge capture, and the lane placement in double-width mode;
- the one-cycle absence of falling-edge data after reset or a reconfiguration.

// File: rtl/pixcap_pkg.sv
package pixcap_pkg;

  typedef enum logic [1:0] {
    WM_HALF   = 2'b00,
    WM_FULL   = 2'b01,
    WM_DOUBLE = 2'b10,
    WM_BAD    = 2'b11
  } width_mode_t;

  typedef enum logic [1:0] {
    EG_NONE = 2'b00,
    EG_RISE = 2'b01,
    EG_FALL = 2'b10,
    EG_BOTH = 2'b11
  } edge_sel_t;

  typedef struct packed {
    width_mode_t wmode;
    edge_sel_t   edge_sel;
    logic        wide;
    logic        low_on_rise;
    logic        two_clk;
  } cfg_t;

endpackage

// File: rtl/pixcap_neg_cap.sv
module pixcap_neg_cap #(
  parameter int BUS_W = 48
) (
  input  logic             clk_p,
  input  logic             clk_n,
  input  logic             two_clk,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] neg_q
);
  logic [BUS_W-1:0] fall_r;
  logic [BUS_W-1:0] nclk_r;

  // sample on the falling edge of the primary clock
  always_ff @(negedge clk_p) begin
    fall_r <= din;
  end

  // sample on the rising edge of the second clock input
  always_ff @(posedge clk_n) begin
    nclk_r <= din;
  end

  assign neg_q = two_clk ? nclk_r : fall_r;

endmodule

// File: rtl/pixcap_guard.sv
module pixcap_guard import pixcap_pkg::*; (
  input  logic clk,
  input  logic rst,
  input  cfg_t cfg,
  output logic chg,
  output logic illegal,
  output logic armed,
  output logic err
);
  cfg_t cfg_q;
  logic armed_q;
  logic err_q;

  assign chg     = (cfg != cfg_q);
  assign illegal = (cfg.wmode == WM_BAD) ||
                   (cfg.wmode == WM_DOUBLE && cfg.edge_sel == EG_BOTH);

  always_ff @(posedge clk) begin
    cfg_q   <= cfg;
    armed_q <= !rst && !chg;
    if (rst) err_q <= 1'b0;
    else     err_q <= err_q | illegal;
  end

  assign armed = armed_q;
  assign err   = err_q;

  // R10: the error flag never drops without reset
  p_err_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

endmodule

// File: rtl/pixcap_half_asm.sv
module pixcap_half_asm #(
  parameter int HALF_W = 12
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                armed,
  input  logic                low_on_rise,
  input  logic [HALF_W-1:0]   rise_half,
  input  logic [HALF_W-1:0]   fall_half,
  output logic [2*HALF_W-1:0] pix,
  output logic                pix_ok
);
  logic [HALF_W-1:0] hold_r;
  logic              hold_vld;

  always_ff @(posedge clk) begin
    hold_r   <= rise_half;
    hold_vld <= !(rst || flush);
  end

  always_comb begin
    if (low_on_rise) begin
      // low piece held from the previous rising edge, high piece from the falling edge after it
      pix    = {fall_half, hold_r};
      pix_ok = hold_vld;
    end else begin
      // low piece from the falling edge, high piece from this rising edge
      pix    = {rise_half, fall_half};
      pix_ok = armed;
    end
  end

endmodule

// File: rtl/pixcap_slot_sel.sv
module pixcap_slot_sel import pixcap_pkg::*; #(
  parameter int PIX_W    = 24,
  parameter int NARROW_W = 18
) (
  input  width_mode_t        wmode,
  input  edge_sel_t          edge_sel,
  input  logic               wide,
  input  logic               armed,
  input  logic [2*PIX_W-1:0] rise_bus,
  input  logic [2*PIX_W-1:0] fall_bus,
  input  logic [PIX_W-1:0]   half_pix,
  input  logic               half_ok,
  output logic [PIX_W-1:0]   s0,
  output logic [PIX_W-1:0]   s1,
  output logic               v0,
  output logic               v1
);
  localparam int PAD_W = PIX_W - NARROW_W;

  logic [PIX_W-1:0] lane_r [2];
  logic [PIX_W-1:0] lane_f [2];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign lane_r[g] = wide ? rise_bus[g*PIX_W +: PIX_W]
                            : {{PAD_W{1'b0}}, rise_bus[g*NARROW_W +: NARROW_W]};
    assign lane_f[g] = wide ? fall_bus[g*PIX_W +: PIX_W]
                            : {{PAD_W{1'b0}}, fall_bus[g*NARROW_W +: NARROW_W]};
  end

  always_comb begin
    s0 = '0;
    s1 = '0;
    v0 = 1'b0;
    v1 = 1'b0;
    case (wmode)
      WM_HALF: begin
        s0 = half_pix;
        v0 = half_ok;
      end
      WM_FULL: begin
        case (edge_sel)
          EG_RISE: begin s0 = lane_r[0]; v0 = 1'b1; end
          EG_FALL: begin s0 = lane_f[0]; v0 = armed; end
          EG_BOTH: begin
            s0 = lane_f[0]; v0 = armed;
            s1 = lane_r[0]; v1 = 1'b1;
          end
          default: ;
        endcase
      end
      WM_DOUBLE: begin
        case (edge_sel)
          EG_RISE: begin
            s0 = lane_r[0]; s1 = lane_r[1];
            v0 = 1'b1;      v1 = 1'b1;
          end
          EG_FALL: begin
            s0 = lane_f[0]; s1 = lane_f[1];
            v0 = armed;     v1 = armed;
          end
          default: ;
        endcase
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/pixcap_top.sv
module pixcap_top import pixcap_pkg::*; #(
  parameter int PIX_W    = 24,
  parameter int NARROW_W = 18
) (
  input  logic               clk_p,
  input  logic               clk_n,
  input  logic               rst,
  input  logic [1:0]         cfg_wmode,
  input  logic [1:0]         cfg_edge,
  input  logic               cfg_wide,
  input  logic               cfg_low_on_rise,
  input  logic               cfg_two_clk,
  input  logic [2*PIX_W-1:0] pix_in,
  output logic [PIX_W-1:0]   slot0_pix,
  output logic               slot0_vld,
  output logic [PIX_W-1:0]   slot1_pix,
  output logic               slot1_vld,
  output logic               cfg_err
);
  localparam int HALF_W = PIX_W / 2;
  localparam int BUS_W  = 2 * PIX_W;

  cfg_t cfg;
  assign cfg.wmode       = width_mode_t'(cfg_wmode);
  assign cfg.edge_sel    = edge_sel_t'(cfg_edge);
  assign cfg.wide        = cfg_wide;
  assign cfg.low_on_rise = cfg_low_on_rise;
  assign cfg.two_clk     = cfg_two_clk;

  logic [BUS_W-1:0] neg_q;
  logic             chg, illegal, armed;
  logic [PIX_W-1:0] half_pix;
  logic             half_ok;
  logic [PIX_W-1:0] n_s0, n_s1;
  logic             n_v0, n_v1;

  pixcap_neg_cap #(.BUS_W(BUS_W)) u_neg (
    .clk_p   (clk_p),
    .clk_n   (clk_n),
    .two_clk (cfg_two_clk),
    .din     (pix_in),
    .neg_q   (neg_q)
  );

  pixcap_guard u_guard (
    .clk     (clk_p),
    .rst     (rst),
    .cfg     (cfg),
    .chg     (chg),
    .illegal (illegal),
    .armed   (armed),
    .err     (cfg_err)
  );

  pixcap_half_asm #(.HALF_W(HALF_W)) u_half (
    .clk         (clk_p),
    .rst         (rst),
    .flush       (chg),
    .armed       (armed),
    .low_on_rise (cfg_low_on_rise),
    .rise_half   (pix_in[HALF_W-1:0]),
    .fall_half   (neg_q[HALF_W-1:0]),
    .pix         (half_pix),
    .pix_ok      (half_ok)
  );

  pixcap_slot_sel #(.PIX_W(PIX_W), .NARROW_W(NARROW_W)) u_sel (
    .wmode    (cfg.wmode),
    .edge_sel (cfg.edge_sel),
    .wide     (cfg_wide),
    .armed    (armed),
    .rise_bus (pix_in),
    .fall_bus (neg_q),
    .half_pix (half_pix),
    .half_ok  (half_ok),
    .s0       (n_s0),
    .s1       (n_s1),
    .v0       (n_v0),
    .v1       (n_v1)
  );

  always_ff @(posedge clk_p) begin
    if (rst || chg || illegal) begin
      slot0_pix <= '0;
      slot1_pix <= '0;
      slot0_vld <= 1'b0;
      slot1_vld <= 1'b0;
    end else begin
      slot0_pix <= n_v0 ? n_s0 : '0;
      slot1_pix <= n_v1 ? n_s1 : '0;
      slot0_vld <= n_v0;
      slot1_vld <= n_v1;
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk_p)
    rst |=> (!slot0_vld && !slot1_vld && !cfg_err));

  p_no_vld_illegal_r10: assert property (@(posedge clk_p) disable iff (rst)
    (cfg_wmode == 2'b11 || (cfg_wmode == 2'b10 && cfg_edge == 2'b11))
      |=> (!slot0_vld && !slot1_vld && cfg_err));

  p_narrow_zero_r3: assert property (@(posedge clk_p) disable iff (rst)
    (cfg_wmode != 2'b00 && !cfg_wide)
      |=> ((!slot0_vld || slot0_pix[PIX_W-1:NARROW_W] == '0) &&
           (!slot1_vld || slot1_pix[PIX_W-1:NARROW_W] == '0)));

  p_cfg_change_r11: assert property (@(posedge clk_p) disable iff (rst)
    (!$past(rst) &&
     {cfg_wmode, cfg_edge, cfg_wide, cfg_low_on_rise, cfg_two_clk} !=
     $past({cfg_wmode, cfg_edge, cfg_wide, cfg_low_on_rise, cfg_two_clk}))
      |=> (!slot0_vld && !slot1_vld));

  p_no_edge_r12: assert property (@(posedge clk_p) disable iff (rst)
    (cfg_wmode != 2'b00 && cfg_edge == 2'b00) |=> (!slot0_vld && !slot1_vld));

  p_half_one_slot_r13: assert property (@(posedge clk_p) disable iff (rst)
    (cfg_wmode == 2'b00) |=> !slot1_vld);

endmodule

// File: tb/sim_pixcap_top.sv
module sim_pixcap_top;

  logic        clk_p = 1'b0;
  logic        clk_n = 1'b0;
  logic        clk_n_en = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_wmode = 2'b01;
  logic [1:0]  cfg_edge = 2'b01;
  logic        cfg_wide = 1'b1;
  logic        cfg_low_on_rise = 1'b0;
  logic        cfg_two_clk = 1'b0;
  logic [47:0] pix_in = '0;
  logic [23:0] slot0_pix, slot1_pix;
  logic        slot0_vld, slot1_vld, cfg_err;

  pixcap_top u0 (
    .clk_p           (clk_p),
    .clk_n           (clk_n),
    .rst             (rst),
    .cfg_wmode       (cfg_wmode),
    .cfg_edge        (cfg_edge),
    .cfg_wide        (cfg_wide),
    .cfg_low_on_rise (cfg_low_on_rise),
    .cfg_two_clk     (cfg_two_clk),
    .pix_in          (pix_in),
    .slot0_pix       (slot0_pix),
    .slot0_vld       (slot0_vld),
    .slot1_pix       (slot1_pix),
    .slot1_vld       (slot1_vld),
    .cfg_err         (cfg_err)
  );

  always #4 clk_p = ~clk_p;
  always @(clk_p) clk_n = clk_n_en & ~clk_p;

  typedef struct packed {
    logic        v0;
    logic        v1;
    logic        err;
    logic [23:0] s0;
    logic [23:0] s1;
  } exp_t;

  exp_t  q_exp[$];
  string q_lbl[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  // reference state
  logic [6:0]  m_prev = '0;
  logic        m_armed = 1'b0;
  logic        m_hv = 1'b0;
  logic [11:0] m_hold = '0;
  logic        m_err = 1'b0;

  function automatic logic [6:0] mk(logic [1:0] w, logic [1:0] e, logic wd, logic lo, logic tc);
    return {w, e, wd, lo, tc};
  endfunction

  function automatic logic [23:0] lane(logic [47:0] b, int idx, logic wd);
    if (wd) return (idx == 0) ? b[23:0] : b[47:24];
    return (idx == 0) ? {6'b0, b[17:0]} : {6'b0, b[35:18]};
  endfunction

  function automatic logic [47:0] rnd48();
    logic [31:0] a;
    logic [31:0] b;
    a = $urandom;
    b = $urandom;
    return {a[15:0], b};
  endfunction

  task automatic chk(string lbl, string what, logic [23:0] act, logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", lbl, what, act, exp);
    end
  endtask

  // driver: one rising edge of clk_p per call
  task automatic step(logic [6:0] c, logic r_v, logic [47:0] fv, logic [47:0] rv, string lbl);
    exp_t x;
    logic chg, ill;
    logic [1:0] w, e;
    logic wd, lo;
    @(posedge clk_p); #2 pix_in = fv;
    @(negedge clk_p); #2 pix_in = rv;
    rst = r_v;
    {cfg_wmode, cfg_edge, cfg_wide, cfg_low_on_rise, cfg_two_clk} = c;
    w = c[6:5]; e = c[4:3]; wd = c[2]; lo = c[1];
    x = '0;
    if (r_v) begin
      m_armed = 1'b0; m_hv = 1'b0; m_err = 1'b0;
    end else begin
      chg = (c != m_prev);
      ill = (w == 2'b11) || (w == 2'b10 && e == 2'b11);
      m_err = m_err | ill;
      case (w)
        2'b00: if (lo) begin x.v0 = m_hv; x.s0 = {fv[11:0], m_hold}; end
               else    begin x.v0 = m_armed; x.s0 = {rv[11:0], fv[11:0]}; end
        2'b01: case (e)
                 2'b01: begin x.v0 = 1'b1; x.s0 = lane(rv, 0, wd); end
                 2'b10: begin x.v0 = m_armed; x.s0 = lane(fv, 0, wd); end
                 2'b11: begin x.v0 = m_armed; x.s0 = lane(fv, 0, wd);
                              x.v1 = 1'b1; x.s1 = lane(rv, 0, wd); end
                 default: ;
               endcase
        2'b10: case (e)
                 2'b01: begin x.v0 = 1'b1; x.v1 = 1'b1;
                              x.s0 = lane(rv, 0, wd); x.s1 = lane(rv, 1, wd); end
                 2'b10: begin x.v0 = m_armed; x.v1 = m_armed;
                              x.s0 = lane(fv, 0, wd); x.s1 = lane(fv, 1, wd); end
                 default: ;
               endcase
        default: ;
      endcase
      if (chg || ill) begin x.v0 = 1'b0; x.v1 = 1'b0; end
      m_hv = !chg;
      m_armed = !chg;
    end
    x.err = m_err;
    m_hold = rv[11:0];
    m_prev = c;
    q_exp.push_back(x);
    q_lbl.push_back(lbl);
  endtask

  // monitor: compares one expected item per rising edge, mid-period
  always @(negedge clk_p) begin
    exp_t  e;
    string l;
    if (q_exp.size() != 0 && !done) begin
      e = q_exp.pop_front();
      l = q_lbl.pop_front();
      chk(l, "slot0_vld", {23'b0, slot0_vld}, {23'b0, e.v0});
      chk(l, "slot1_vld", {23'b0, slot1_vld}, {23'b0, e.v1});
      chk(l, "cfg_err",   {23'b0, cfg_err},   {23'b0, e.err});
      if (e.v0) chk(l, "slot0_pix", slot0_pix, e.s0);
      if (e.v1) chk(l, "slot1_pix", slot1_pix, e.s1);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [6:0] c;
    // R1: reset
    c = mk(2'b01, 2'b01, 1'b1, 1'b0, 1'b0);
    step(c, 1'b1, '0, '0, "R1");
    step(c, 1'b1, '0, '0, "R1");
    // R2: full width, rising edge, 24-bit
    for (int i = 0; i < 5; i++) step(c, 1'b0, rnd48(), rnd48(), "R2");
    // R3: 18-bit pixels, zero-extended
    c = mk(2'b01, 2'b01, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(c, 1'b0, rnd48(), 48'hFFFF_FFFF_FFFF, "R3");
    // R4: falling edge
    c = mk(2'b01, 2'b10, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(c, 1'b0, rnd48(), rnd48(), "R4");
    // R5: both edges, then the first cycle after reset
    c = mk(2'b01, 2'b11, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(c, 1'b0, rnd48(), rnd48(), "R5");
    step(c, 1'b1, rnd48(), rnd48(), "R5");
    for (int i = 0; i < 4; i++) step(c, 1'b0, rnd48(), rnd48(), "R5");
    // R6: half width, low piece on rising edge
    c = mk(2'b00, 2'b11, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) step(c, 1'b0, rnd48(), rnd48(), "R6");
    // R7: half width, low piece on falling edge
    c = mk(2'b00, 2'b11, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) step(c, 1'b0, rnd48(), rnd48(), "R7");
    // R8: two-clock half-width variant, both orders
    clk_n_en = 1'b1;
    c = mk(2'b00, 2'b01, 1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 5; i++) step(c, 1'b0, rnd48(), rnd48(), "R8");
    c = mk(2'b00, 2'b01, 1'b1, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) step(c, 1'b0, rnd48(), rnd48(), "R8");
    clk_n_en = 1'b0;
    // R9: double width, rising 24-bit and falling 18-bit
    c = mk(2'b10, 2'b01, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(c, 1'b0, rnd48(), rnd48(), "R9");
    c = mk(2'b10, 2'b10, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 4; i++) step(c, 1'b0, rnd48(), rnd48(), "R9");
    // R11: order flip while a half pixel is pending
    c = mk(2'b00, 2'b11, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step(c, 1'b0, rnd48(), rnd48(), "R11");
    c = mk(2'b00, 2'b11, 1'b1, 1'b0, 1'b0);
    step(c, 1'b0, rnd48(), rnd48(), "R11");
    c = mk(2'b00, 2'b11, 1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step(c, 1'b0, rnd48(), rnd48(), "R11");
    // R12: no edge selected
    c = mk(2'b01, 2'b00, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(c, 1'b0, rnd48(), rnd48(), "R12");
    c = mk(2'b10, 2'b00, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(c, 1'b0, rnd48(), rnd48(), "R12");
    // R10: illegal configurations, sticky flag, cleared by reset
    c = mk(2'b10, 2'b11, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(c, 1'b0, rnd48(), rnd48(), "R10");
    c = mk(2'b01, 2'b01, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(c, 1'b0, rnd48(), rnd48(), "R10");
    c = mk(2'b11, 2'b01, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 2; i++) step(c, 1'b0, rnd48(), rnd48(), "R10");
    step(c, 1'b1, rnd48(), rnd48(), "R10");
    c = mk(2'b01, 2'b01, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(c, 1'b0, rnd48(), rnd48(), "R10");
    // drain
    @(posedge clk_p);
    @(posedge clk_p);
    @(negedge clk_p);
    #1;
    finish_run();
  end

endmodule